// File: doc/BRIEF.md
# Producer-paced inbound quadword DMA channel

This block is one receive channel of a DMA controller. A decoder-like producer pushes 128-bit quadwords over a valid/ready stream, and the channel writes each one to memory at its current address. Software programs a destination address and a quadword count, then sets the run bit in the control register. Setting the run bit does not move any data. The channel takes a quadword only in a cycle where the producer offers one, the run bit is set and the remaining count is not zero. It takes at most one quadword per clock.

Each accepted quadword advances the address by 16 bytes and lowers the count by one. Address bit 31 selects the scratchpad region. Otherwise the address is folded into the main RAM window. A stall-address register can follow the write pointer, so a downstream reader of the same buffer can be held back. It does this only when the stall-source register names this channel. When the count reaches zero, the run bit clears and a one-cycle completion pulse is raised.

Top module: `dma_in_stream_ch`

## Requirements
- R1: After reset, all five registers read zero, and in_ready, mem_we and done are all low.
- R2: A control write (index 0) only stores the value. in_ready is high exactly when control bit 8 (run) is set and the count is nonzero. While run is clear, offered data is not taken, and the count and address stay unchanged.
- R3: A write to the address register (index 1) or to the stall register (index 3) stores the value with bits [3:0] forced to zero.
- R4: Each accepted quadword makes a same-cycle memory write of in_data at the current address. The address then grows by 16 and the count (index 2) drops by 1. Back-to-back offers are accepted on consecutive clocks.
- R5: When address bit 31 is 1, mem_spr is 1 and mem_addr is the address modulo 2^SPR_AW. When bit 31 is 0, mem_spr is 0 and mem_addr is the address modulo 2^RAM_AW.
- R6: When the stall-source register (index 4, bits [1:0]) equals OWN_SRC (default 3), each accepted quadword loads the stall register with the advanced address. For any other value the stall register keeps its contents.
- R7: The quadword that brings the count to zero clears control bit 8 and leaves the other control bits as written. done is high for exactly one cycle, the cycle after that quadword.
- R8: With the run bit set and a count of zero, nothing is accepted and done stays low.
- R9: A register write in the same cycle as an accepted quadword overrides the engine's update of that register. The other registers still advance.
- R10: Register indices 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| in_valid | input | 1 | Producer offers a quadword |
| in_ready | output | 1 | Channel will take the offered quadword |
| in_data | input | 128 | Offered quadword |
| mem_we | output | 1 | Memory write strobe |
| mem_spr | output | 1 | 1 selects scratchpad, 0 selects main RAM |
| mem_addr | output | MAP_W (16) | Byte address inside the selected region |
| mem_data | output | 128 | Memory write data |
| done | output | 1 | One-cycle completion pulse |
| stall_addr | output | 32 | Current stall address |

## Verification
The bound checker checks these rules on every cycle:
- in_ready is high only while the run bit is set and the count is nonzero.
- Each unobstructed acceptance moves the address up by 16 and the count down by one.
- Memory writes stay quadword aligned.
- The stall register follows the pointer while tracking is on.
- done follows only the final quadword and clears the run bit.

Other behaviour can only be shown by the bench's scenarios:
- the region folding at the window edges;
- the exact readback values after whole transfers with and without producer gaps;
- the precedence of a register write that collides with a beat;
- that writes to unused indices have no effect.

// File: rtl/dma_in_pkg.sv
package dma_in_pkg;

    localparam int REG_W    = 32;
    localparam int QW_BYTES = 16;

    typedef enum logic [2:0] {
        RI_CTL   = 3'd0,
        RI_ADDR  = 3'd1,
        RI_CNT   = 3'd2,
        RI_STALL = 3'd3,
        RI_SRC   = 3'd4
    } reg_idx_e;

    localparam logic [REG_W-1:0] ALIGN_MASK = ~(REG_W'(QW_BYTES) - 1'b1);

endpackage

// File: rtl/dma_in_beat.sv
module dma_in_beat #(
    parameter int QWC_W = 16
) (
    input  logic             in_valid,
    input  logic             run,
    input  logic [QWC_W-1:0] qwc,
    output logic             in_ready,
    output logic             acc,
    output logic             last
);
    logic cnt_nz;

    always_comb begin
        cnt_nz   = (qwc != '0);
        in_ready = run && cnt_nz;
        acc      = in_ready && in_valid;
        last     = acc && (qwc == QWC_W'(1));
    end
endmodule

// File: rtl/dma_in_addr_map.sv
module dma_in_addr_map #(
    parameter int RAM_AW = 16,
    parameter int SPR_AW = 14,
    parameter int MAP_W  = 16
) (
    input  logic [31:0]      madr,
    output logic             spr,
    output logic [MAP_W-1:0] addr
);
    logic [MAP_W-1:0] ram_part;
    logic [MAP_W-1:0] spr_part;

    // Fold the pointer into the window of its region; bit 31 picks the region.
    always_comb begin
        ram_part = MAP_W'(madr[RAM_AW-1:0]);
        spr_part = MAP_W'(madr[SPR_AW-1:0]);
        spr      = madr[31];
        addr     = spr ? spr_part : ram_part;
    end
endmodule

// File: rtl/dma_in_rdmux.sv
module dma_in_rdmux #(
    parameter int QWC_W = 16,
    parameter int SRC_W = 2
) (
    input  logic [2:0]       idx,
    input  logic [31:0]      ctl,
    input  logic [31:0]      madr,
    input  logic [QWC_W-1:0] qwc,
    input  logic [31:0]      stall,
    input  logic [SRC_W-1:0] src,
    output logic [31:0]      rdata
);
    import dma_in_pkg::*;

    always_comb begin
        case (idx)
            RI_CTL:   rdata = ctl;
            RI_ADDR:  rdata = madr;
            RI_CNT:   rdata = 32'(qwc);
            RI_STALL: rdata = stall;
            RI_SRC:   rdata = 32'(src);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_in_stream_ch.sv
module dma_in_stream_ch #(
    parameter int                 DW        = 128,
    parameter int                 QWC_W     = 16,
    parameter int                 RAM_AW    = 16,
    parameter int                 SPR_AW    = 14,
    parameter int                 SRC_W     = 2,
    parameter logic [SRC_W-1:0]   OWN_SRC   = 2'd3,
    parameter int                 RUN_BIT   = 8,
    parameter int                 MAP_W     = (RAM_AW > SPR_AW) ? RAM_AW : SPR_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_data,
    output logic             mem_we,
    output logic             mem_spr,
    output logic [MAP_W-1:0] mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic             done,
    output logic [31:0]      stall_addr
);
    import dma_in_pkg::*;

    localparam logic [31:0] STEP = 32'(QW_BYTES);

    typedef struct packed {
        logic [31:0]      ctl;
        logic [31:0]      madr;
        logic [QWC_W-1:0] qwc;
        logic [31:0]      stall;
        logic [SRC_W-1:0] src;
        logic             done;
    } ch_state_t;

    ch_state_t s_d, s_q;

    logic             acc;
    logic             last;
    logic             track;
    logic             cur_run;
    logic [31:0]      cur_madr;
    logic [QWC_W-1:0] cur_qwc;

    assign cur_run  = s_q.ctl[RUN_BIT];
    assign cur_madr = s_q.madr;
    assign cur_qwc  = s_q.qwc;
    assign track    = (s_q.src == OWN_SRC);

    dma_in_beat #(.QWC_W(QWC_W)) beat_i (
        .in_valid (in_valid),
        .run      (cur_run),
        .qwc      (s_q.qwc),
        .in_ready (in_ready),
        .acc      (acc),
        .last     (last)
    );

    dma_in_addr_map #(.RAM_AW(RAM_AW), .SPR_AW(SPR_AW), .MAP_W(MAP_W)) map_i (
        .madr (s_q.madr),
        .spr  (mem_spr),
        .addr (mem_addr)
    );

    dma_in_rdmux #(.QWC_W(QWC_W), .SRC_W(SRC_W)) rd_i (
        .idx   (reg_addr),
        .ctl   (s_q.ctl),
        .madr  (s_q.madr),
        .qwc   (s_q.qwc),
        .stall (s_q.stall),
        .src   (s_q.src),
        .rdata (reg_rdata)
    );

    assign mem_we     = acc;
    assign mem_data   = in_data;
    assign done       = s_q.done;
    assign stall_addr = s_q.stall;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        // Engine update for an accepted quadword.
        if (acc) begin
            s_d.madr = s_q.madr + STEP;
            s_d.qwc  = s_q.qwc - 1'b1;
            if (track) begin
                s_d.stall = s_d.madr;
            end
            if (last) begin
                s_d.ctl[RUN_BIT] = 1'b0;
                s_d.done         = 1'b1;
            end
        end

        // A software write wins over the engine for the register it names.
        if (reg_we) begin
            case (reg_addr)
                RI_CTL:   s_d.ctl   = reg_wdata;
                RI_ADDR:  s_d.madr  = reg_wdata & ALIGN_MASK;
                RI_CNT:   s_d.qwc   = reg_wdata[QWC_W-1:0];
                RI_STALL: s_d.stall = reg_wdata & ALIGN_MASK;
                RI_SRC:   s_d.src   = reg_wdata[SRC_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dma_in_chk.sv
module dma_in_chk #(
    parameter int QWC_W = 16,
    parameter int MAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             in_ready,
    input logic             mem_we,
    input logic [MAP_W-1:0] mem_addr,
    input logic             done,
    input logic             acc,
    input logic             last,
    input logic             track,
    input logic             cur_run,
    input logic [31:0]      cur_madr,
    input logic [QWC_W-1:0] cur_qwc,
    input logic [31:0]      stall_addr
);
    p_ready_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> cur_run);

    p_zero_count_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_qwc == '0) |-> !in_ready);

    p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !reg_we) |=> (cur_madr == $past(cur_madr) + 32'd16)
                             && (cur_qwc == $past(cur_qwc) - 1'b1));

    p_write_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[3:0] == 4'd0));

    p_stall_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && track && !reg_we) |=> (stall_addr == cur_madr));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !reg_we) |=> (done && !cur_run));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind dma_in_stream_ch dma_in_chk #(.QWC_W(QWC_W), .MAP_W(MAP_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .in_ready   (in_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .done       (done),
    .acc        (acc),
    .last       (last),
    .track      (track),
    .cur_run    (cur_run),
    .cur_madr   (cur_madr),
    .cur_qwc    (cur_qwc),
    .stall_addr (stall_addr)
);

// File: tb/dma_in_stream_ch_tb_top.sv
`timescale 1ns/1ps
module dma_in_stream_ch_tb_top;

    localparam int MAP_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [127:0]     in_data = '0;
    logic             mem_we;
    logic             mem_spr;
    logic [MAP_W-1:0] mem_addr;
    logic [127:0]     mem_data;
    logic             done;
    logic [31:0]      stall_addr;

    int checks = 0;
    int errs   = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    dma_in_stream_ch dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .mem_we(mem_we),
        .mem_spr(mem_spr), .mem_addr(mem_addr), .mem_data(mem_data),
        .done(done), .stall_addr(stall_addr)
    );

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = idx; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_addr = idx;
        #1;
        v = reg_rdata;
    endtask

    // Full transfer with a model of address, count, region folding and done timing.
    task automatic run(input logic [31:0] a0, input int n, input bit gaps, input bit trk);
        logic [31:0] ea;
        logic [31:0] v;
        logic [15:0] ema;
        int rem;
        bit last_prev;
        int dones;
        wr(3'd4, trk ? 32'd3 : 32'd1);
        wr(3'd3, 32'h0000_0BC0);
        wr(3'd1, a0);
        wr(3'd2, 32'(n));
        wr(3'd0, 32'h0000_01A5);
        ea = a0; rem = n; last_prev = 0; dones = 0;
        for (int k = 0; k < 3 * n + 3; k++) begin
            in_valid = gaps ? (k % 2 == 0) : 1'b1;
            in_data  = {4{ea ^ 32'(k)}};
            #1;
            if (done) dones++;
            chk("R7 done timing", 128'(done), 128'(last_prev));
            chk("R2 ready", 128'(in_ready), 128'(rem > 0));
            last_prev = 0;
            if (in_valid && rem > 0) begin
                ema = ea[31] ? {2'b00, ea[13:0]} : ea[15:0];
                chk("R4 mem_we", 128'(mem_we), 128'd1);
                chk("R4 mem_data", mem_data, {4{ea ^ 32'(k)}});
                chk("R5 region", 128'(mem_spr), 128'(ea[31]));
                chk("R5 mem_addr", 128'(mem_addr), 128'(ema));
                ea  = ea + 32'd16;
                rem = rem - 1;
                if (rem == 0) last_prev = 1;
            end else begin
                chk("R2 no write", 128'(mem_we), 128'd0);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        rd(3'd1, v); chk("R4 final address", 128'(v), 128'(ea));
        rd(3'd2, v); chk("R4 final count", 128'(v), 128'd0);
        rd(3'd0, v); chk("R7 run cleared", 128'(v), 128'h0A5);
        rd(3'd3, v); chk("R6 stall value", 128'(v), 128'(trk ? ea : 32'h0BC0));
        chk("R7 single done", 128'(dones), 128'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v); chk("R1 reset reg", 128'(v), 128'd0);
        end
        chk("R1 reset outputs", 128'({in_ready, mem_we, done}), 128'd0);

        // R3 alignment masking
        wr(3'd1, 32'h1234_567F); rd(3'd1, v); chk("R3 addr mask", 128'(v), 128'h1234_5670);
        wr(3'd3, 32'h0000_0ABF); rd(3'd3, v); chk("R3 stall mask", 128'(v), 128'h0AB0);

        // R10 unused indices
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v); chk("R10 unused read", 128'(v), 128'd0);
        rd(3'd5, v); chk("R10 unused read", 128'(v), 128'd0);
        rd(3'd7, v); chk("R10 unused read", 128'(v), 128'd0);
        rd(3'd1, v); chk("R10 no side effect", 128'(v), 128'h1234_5670);
        rd(3'd0, v); chk("R10 no side effect", 128'(v), 128'd0);

        // R2 run clear: data offered but not taken
        wr(3'd2, 32'd3);
        wr(3'd0, 32'h0000_00FF);
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1; chk("R2 idle ready", 128'({in_ready, mem_we}), 128'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rd(3'd2, v); chk("R2 count kept", 128'(v), 128'd3);
        rd(3'd1, v); chk("R2 addr kept", 128'(v), 128'h1234_5670);

        // R8 run with zero count
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h0000_0100);
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1; chk("R8 zero count", 128'({in_ready, mem_we, done}), 128'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        wr(3'd0, 32'd0);

        // R4 R5 R6 R7 sweep over regions, lengths, gaps and tracking
        for (int r = 0; r < 4; r++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [31:0] base;
                    case (r)
                        0: base = 32'h0000_0100;
                        1: base = 32'h0003_FFE0;
                        2: base = 32'h8000_0040;
                        default: base = 32'h8000_3FE0;
                    endcase
                    run(base, n, g[0], (r + n) % 2 == 0);
                end
            end
        end

        // R9 register write colliding with a beat
        wr(3'd4, 32'd1);
        wr(3'd1, 32'h0000_2000);
        wr(3'd2, 32'd4);
        wr(3'd0, 32'h0000_0100);
        in_valid = 1'b1; in_data = '1;
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd10;
        #1; chk("R9 beat taken", 128'(mem_we), 128'd1);
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        rd(3'd2, v); chk("R9 write wins", 128'(v), 128'd10);
        rd(3'd1, v); chk("R9 addr advanced", 128'(v), 128'h2010);
        wr(3'd0, 32'd0);

        report();
    end
endmodule